// File: doc/BRIEF.md
# Masked Vector Tuple Broadcast Unit

This block fills a destination vector register of 128, 256 or 512 bits with copies of a short source tuple. The tuple holds 1, 2, 4 or 8 elements, and each element is 32 or 64 bits wide. Destination element j takes source element (j mod T), where T is the tuple element count. A per-element write mask then decides what each destination element receives. An enabled element gets the broadcast value. A disabled element either keeps the value it had in the old destination (merge) or is cleared (zero). Every bit above the selected vector length is forced to zero.

The unit sits in an execution pipeline. It is handed the source tuple, the old destination contents, the mask and the operation's shape, all qualified by a valid strobe. Exactly one cycle later it returns the new destination value together with a valid flag and a write-enable. It also checks each request against the legal shape and length combinations, and against a 4-bit reserved specifier field that must be all ones. A request that fails either check raises an illegal flag. It suppresses the write-enable and leaves the destination output at its previous value.

Top module: `vecTupleBcast`

## Requirements
- R1: With 32-bit elements (elemWide=0), destination element j is destOut[32j+31:32j] and receives source element (j mod T) from srcTuple[32n+31:32n]. T is set by tupleSel: 0 gives 1 element, 1 gives 2, 2 gives 4 and 3 gives 8.
- R2: With 64-bit elements (elemWide=1), destination element j is destOut[64j+63:64j] and receives srcTuple[64n+63:64n], where n = j mod T.
- R3: When maskEn=0 the maskBits input is ignored and every active element receives the broadcast value.
- R4: When maskEn=1, maskBits[j]=0 and zeroMode=0 (merge), destination element j equals the same element of oldDest. Mask bit j belongs to element j for both element widths.
- R5: When maskEn=1, maskBits[j]=0 and zeroMode=1, destination element j is written as zero.
- R6: vecLen selects the vector length: 0 gives 128 bits, 1 gives 256 and 2 gives 512. All destOut bits at or above the selected length are zero after a legal operation.
- R7: The following combinations are illegal and set illegalOut:
  - vecLen=3;
  - any tuple other than a single 32-bit element at 128 bits;
  - an 8×32-bit or 4×64-bit tuple below 512 bits;
  - an 8×64-bit tuple at any length.
- R8: A specField value other than 4'b1111 sets illegalOut.
- R9: For an illegal operation, outValid is 1, illegalOut is 1, writeEn is 0, and destOut keeps its previous value.
- R10: The result of a request taken with inValid=1 appears one clock later with outValid=1. A legal result also has writeEn=1. In cycles with no result, outValid and writeEn are 0 and destOut is unchanged.
- R11: A synchronous active-high rst clears destOut, outValid, writeEn and illegalOut to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe |
| srcTuple | input | 256 | Source tuple, element 0 in the low bits |
| oldDest | input | 512 | Current destination contents, used for merging |
| maskBits | input | 16 | Per-element write mask |
| maskEn | input | 1 | 1 applies the mask, 0 ignores it |
| zeroMode | input | 1 | 1 zeroes masked-off elements, 0 merges them |
| vecLen | input | 2 | Vector length select (128/256/512, 3 reserved) |
| elemWide | input | 1 | 0 selects 32-bit elements, 1 selects 64-bit elements |
| tupleSel | input | 2 | Tuple element count as a power of two |
| specField | input | 4 | Reserved specifier, must be 4'b1111 |
| outValid | output | 1 | Result valid, one cycle after inValid |
| writeEn | output | 1 | Result is legal and may be written |
| illegalOut | output | 1 | Result belongs to an illegal request |
| destOut | output | 512 | New destination value |

## Verification
Every result of this unit is due exactly one clock edge after the cycle in which inValid was high, and nothing is due at any other time. The driver applies a request at a falling edge and pushes the expected destination and illegal flag into a queue at that moment. The monitor samples at every following falling edge. When it sees outValid it pops one entry and compares destOut, illegalOut and writeEn. When outValid is low it checks that writeEn is low and that destOut still equals the last popped value. Because of this, a result that arrives a cycle early or late, or an illegal request that disturbs destOut, shows up as a mismatch rather than slipping through.

// File: rtl/vtb_pkg.sv
package vtb_pkg;

  typedef enum logic [1:0] {
    LEN_128  = 2'd0,
    LEN_256  = 2'd1,
    LEN_512  = 2'd2,
    LEN_RSVD = 2'd3
  } vecLen_e;

  typedef enum logic [1:0] {
    TUP_1 = 2'd0,
    TUP_2 = 2'd1,
    TUP_4 = 2'd2,
    TUP_8 = 2'd3
  } tupleCnt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic commit;   // legal request accepted: load new destination
    logic capture;  // any request accepted this cycle
  } ctrlStrobe_t;

  localparam logic [3:0] SPEC_ONES = 4'hF;

endpackage

// File: rtl/vtbCtrl.sv
module vtbCtrl
  import vtb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  vecLen,
  input  logic        elemWide,
  input  logic [1:0]  tupleSel,
  input  logic [3:0]  specField,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        writeEn,
  output logic        illegalOut
);

  vecLen_e   lenSel;
  tupleCnt_e tupSel;
  logic      shapeOk;
  logic      legal;

  assign lenSel = vecLen_e'(vecLen);
  assign tupSel = tupleCnt_e'(tupleSel);

  // legal length for each element width / tuple size pair
  always_comb begin
    shapeOk = 1'b0;
    if (!elemWide) begin
      unique case (tupSel)
        TUP_1:        shapeOk = (lenSel != LEN_RSVD);
        TUP_2, TUP_4: shapeOk = (lenSel == LEN_256) || (lenSel == LEN_512);
        TUP_8:        shapeOk = (lenSel == LEN_512);
        default:      shapeOk = 1'b0;
      endcase
    end else begin
      unique case (tupSel)
        TUP_1, TUP_2: shapeOk = (lenSel == LEN_256) || (lenSel == LEN_512);
        TUP_4:        shapeOk = (lenSel == LEN_512);
        TUP_8:        shapeOk = 1'b0;
        default:      shapeOk = 1'b0;
      endcase
    end
  end

  assign legal          = shapeOk && (specField == SPEC_ONES);
  assign strobe.capture = inValid;
  assign strobe.commit  = inValid && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      writeEn    <= 1'b0;
      illegalOut <= 1'b0;
    end else begin
      outValid   <= strobe.capture;
      writeEn    <= strobe.commit;
      illegalOut <= strobe.capture && !legal;
    end
  end

endmodule

// File: rtl/vtbDatapath.sv
module vtbDatapath
  import vtb_pkg::*;
#(
  parameter int unsigned LANE_W    = 32,
  parameter int unsigned MAX_LANES = 16,
  parameter int unsigned SRC_LANES = 8,
  localparam int unsigned DEST_W   = LANE_W * MAX_LANES,
  localparam int unsigned SRC_W    = LANE_W * SRC_LANES,
  localparam int unsigned MASK_W   = MAX_LANES
)(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [SRC_W-1:0]  srcTuple,
  input  logic [DEST_W-1:0] oldDest,
  input  logic [MASK_W-1:0] maskBits,
  input  logic              maskEn,
  input  logic              zeroMode,
  input  logic [1:0]        vecLen,
  input  logic              elemWide,
  input  logic [1:0]        tupleSel,
  output logic [DEST_W-1:0] destOut
);

  localparam int unsigned MIN_LANES = 4; // lanes in the shortest vector

  logic [DEST_W-1:0] nextDest;
  int unsigned       tupleMod;
  int unsigned       activeLanes;

  assign tupleMod    = (32'd1 << tupleSel) - 32'd1;
  assign activeLanes = MIN_LANES << vecLen;

  // each lane is 32 bits; a 64-bit element spans lanes 2e and 2e+1
  for (genvar L = 0; L < MAX_LANES; L++) begin : g_lane
    localparam int unsigned PAIR = L / 2;
    localparam int unsigned HALF = L % 2;
    logic [LANE_W-1:0] laneVal;
    int unsigned       srcLane;
    logic              maskOn;

    always_comb begin
      if (elemWide) srcLane = (((PAIR & tupleMod) << 1) | HALF) % SRC_LANES;
      else          srcLane = (L & tupleMod) % SRC_LANES;

      if (!maskEn)       maskOn = 1'b1;
      else if (elemWide) maskOn = maskBits[PAIR];
      else               maskOn = maskBits[L];

      if (L >= activeLanes) laneVal = '0;
      else if (maskOn)      laneVal = srcTuple[srcLane*LANE_W +: LANE_W];
      else if (zeroMode)    laneVal = '0;
      else                  laneVal = oldDest[L*LANE_W +: LANE_W];
    end

    assign nextDest[L*LANE_W +: LANE_W] = laneVal;
  end

  always_ff @(posedge clk) begin
    if (rst)                destOut <= '0;
    else if (strobe.commit) destOut <= nextDest;
  end

endmodule

// File: rtl/vecTupleBcast.sv
module vecTupleBcast
  import vtb_pkg::*;
#(
  parameter int unsigned LANE_W    = 32,
  parameter int unsigned MAX_LANES = 16,
  parameter int unsigned SRC_LANES = 8,
  localparam int unsigned DEST_W   = LANE_W * MAX_LANES,
  localparam int unsigned SRC_W    = LANE_W * SRC_LANES
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [SRC_W-1:0]  srcTuple,
  input  logic [DEST_W-1:0] oldDest,
  input  logic [MAX_LANES-1:0] maskBits,
  input  logic              maskEn,
  input  logic              zeroMode,
  input  logic [1:0]        vecLen,
  input  logic              elemWide,
  input  logic [1:0]        tupleSel,
  input  logic [3:0]        specField,
  output logic              outValid,
  output logic              writeEn,
  output logic              illegalOut,
  output logic [DEST_W-1:0] destOut
);

  ctrlStrobe_t strobe;

  vtbCtrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .vecLen     (vecLen),
    .elemWide   (elemWide),
    .tupleSel   (tupleSel),
    .specField  (specField),
    .strobe     (strobe),
    .outValid   (outValid),
    .writeEn    (writeEn),
    .illegalOut (illegalOut)
  );

  vtbDatapath #(
    .LANE_W    (LANE_W),
    .MAX_LANES (MAX_LANES),
    .SRC_LANES (SRC_LANES)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .srcTuple (srcTuple),
    .oldDest  (oldDest),
    .maskBits (maskBits),
    .maskEn   (maskEn),
    .zeroMode (zeroMode),
    .vecLen   (vecLen),
    .elemWide (elemWide),
    .tupleSel (tupleSel),
    .destOut  (destOut)
  );

endmodule

// File: rtl/vtbChecker.sv
module vtbChecker #(
  parameter int unsigned DEST_W = 512
)(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [1:0]        vecLen,
  input logic [3:0]        specField,
  input logic              outValid,
  input logic              writeEn,
  input logic              illegalOut,
  input logic [DEST_W-1:0] destOut
);

  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !writeEn));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(destOut));

  p_spec_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (inValid && specField != 4'hF) |=> illegalOut);

  p_len_rsvd_r7: assert property (@(posedge clk) disable iff (rst)
    (inValid && vecLen == 2'd3) |=> illegalOut);

  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (outValid && illegalOut) |-> ($stable(destOut) && !writeEn));

  p_we_legal_r9: assert property (@(posedge clk) disable iff (rst)
    writeEn |-> (outValid && !illegalOut));

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (writeEn && $past(vecLen) == 2'd0) |-> (destOut[DEST_W-1:128] == '0));

endmodule

bind vecTupleBcast vtbChecker #(.DEST_W(DEST_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .vecLen     (vecLen),
  .specField  (specField),
  .outValid   (outValid),
  .writeEn    (writeEn),
  .illegalOut (illegalOut),
  .destOut    (destOut)
);

// File: tb/vecTupleBcast_tb_top.sv
module vecTupleBcast_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [255:0] srcTuple = '0;
  logic [511:0] oldDest = '0;
  logic [15:0]  maskBits = '0;
  logic         maskEn = 1'b0;
  logic         zeroMode = 1'b0;
  logic [1:0]   vecLen = '0;
  logic         elemWide = 1'b0;
  logic [1:0]   tupleSel = '0;
  logic [3:0]   specField = 4'hF;
  logic         outValid, writeEn, illegalOut;
  logic [511:0] destOut;

  int errors = 0;
  int checks = 0;
  bit monOn = 1'b0;
  bit finished = 1'b0;

  logic [511:0] expDestQ[$];
  bit           expIllQ[$];
  string        tagQ[$];
  logic [511:0] modelDest = '0;  // driver-side last legal result
  logic [511:0] heldDest = '0;   // monitor-side last seen result

  always #2 clk = ~clk;  // 250 MHz

  vecTupleBcast dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .srcTuple(srcTuple),
    .oldDest(oldDest), .maskBits(maskBits), .maskEn(maskEn),
    .zeroMode(zeroMode), .vecLen(vecLen), .elemWide(elemWide),
    .tupleSel(tupleSel), .specField(specField), .outValid(outValid),
    .writeEn(writeEn), .illegalOut(illegalOut), .destOut(destOut)
  );

  function automatic bit refLegal(int len, bit w, int ts, logic [3:0] spec);
    int tupBits;
    int minBits;
    if (spec != 4'hF) return 1'b0;
    if (len == 3) return 1'b0;
    tupBits = (1 << ts) * (w ? 64 : 32);
    if (tupBits > 256) return 1'b0;
    if (!w && ts == 0) minBits = 128;
    else if (tupBits == 256) minBits = 512;
    else minBits = 256;
    return (128 << len) >= minBits;
  endfunction

  function automatic logic [511:0] refDest(logic [255:0] s, logic [511:0] o,
      logic [15:0] m, int len, bit w, int ts, bit z, bit me);
    logic [511:0] r = '0;
    int bits = 128 << len;
    int t = 1 << ts;
    if (!w) begin
      for (int j = 0; j < bits / 32; j++) begin
        if (!me || m[j]) r[j*32 +: 32] = s[(j % t)*32 +: 32];
        else if (!z)     r[j*32 +: 32] = o[j*32 +: 32];
      end
    end else begin
      for (int j = 0; j < bits / 64; j++) begin
        if (!me || m[j]) r[j*64 +: 64] = s[(j % t)*64 +: 64];
        else if (!z)     r[j*64 +: 64] = o[j*64 +: 64];
      end
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // driver: called at a falling edge, leaves inValid high for one cycle
  task automatic sendOp(logic [255:0] s, logic [511:0] o, logic [15:0] m,
      int len, bit w, int ts, bit z, bit me, logic [3:0] spec, string tag);
    bit lg;
    srcTuple = s; oldDest = o; maskBits = m; vecLen = 2'(len);
    elemWide = w; tupleSel = 2'(ts); zeroMode = z; maskEn = me;
    specField = spec; inValid = 1'b1;
    lg = refLegal(len, w, ts, spec);
    if (lg) modelDest = refDest(s, o, m, len, w, ts, z, me);
    expDestQ.push_back(modelDest);
    expIllQ.push_back(!lg);
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [511:0] rnd512();
    return {rnd256(), rnd256()};
  endfunction

  // monitor
  always @(negedge clk) begin
    if (monOn && !rst) begin
      if (outValid) begin
        if (expDestQ.size() == 0) begin
          check(1'b0, "R10", "unexpected outValid", 512'(outValid), 512'd0);
        end else begin
          logic [511:0] e;
          bit ei;
          string tg;
          e = expDestQ.pop_front();
          ei = expIllQ.pop_front();
          tg = tagQ.pop_front();
          check(destOut === e, tg, "destOut", destOut, e);
          check(illegalOut === ei, ei ? "R9" : tg, "illegalOut", 512'(illegalOut), 512'(ei));
          check(writeEn === !ei, "R9", "writeEn", 512'(writeEn), 512'(!ei));
          heldDest = e;
        end
      end else begin
        check(writeEn === 1'b0, "R10", "idle writeEn", 512'(writeEn), 512'd0);
        check(destOut === heldDest, "R10", "idle destOut", destOut, heldDest);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] s;
    logic [511:0] o;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(destOut === '0, "R11", "destOut", destOut, '0);
    check(outValid === 1'b0, "R11", "outValid", 512'(outValid), 512'd0);
    check(writeEn === 1'b0, "R11", "writeEn", 512'(writeEn), 512'd0);
    check(illegalOut === 1'b0, "R11", "illegalOut", 512'(illegalOut), 512'd0);
    monOn = 1'b1;

    s = rnd256(); o = rnd512();
    // R1/R3: single 32-bit element, 512 bits, mask ignored (all zeros)
    sendOp(s, o, 16'h0000, 2, 0, 0, 1, 0, 4'hF, "R3");
    idle(2);
    // R1/R4: 4-element tuple, merge
    sendOp(s, o, 16'hA5C3, 2, 0, 2, 0, 1, 4'hF, "R4");
    idle(1);
    // R5: 8-element tuple, zeroing
    sendOp(s, o, 16'h3C96, 2, 0, 3, 1, 1, 4'hF, "R5");
    idle(1);
    // R2/R6: 2x64 at 256 bits, merge, upper half zero
    sendOp(s, o, 16'h0005, 1, 1, 1, 0, 1, 4'hF, "R2");
    // R2: 4x64 at 512, zeroing
    sendOp(s, o, 16'h00B4, 2, 1, 2, 1, 1, 4'hF, "R2");
    // R6: 32-bit single at 128 bits, upper bits of old data must vanish
    sendOp(s, {512{1'b1}}, 16'h0006, 0, 0, 0, 0, 1, 4'hF, "R6");
    // R1: 2-element 32-bit tuple at 256
    sendOp(s, o, 16'hFFFF, 1, 0, 1, 0, 1, 4'hF, "R1");
    idle(2);
    // R7 illegal shapes; R9 hold
    sendOp(s, o, 16'hFFFF, 0, 1, 0, 0, 0, 4'hF, "R7");
    sendOp(s, o, 16'hFFFF, 1, 0, 3, 0, 0, 4'hF, "R7");
    sendOp(s, o, 16'hFFFF, 2, 1, 3, 0, 0, 4'hF, "R7");
    sendOp(s, o, 16'hFFFF, 3, 0, 0, 0, 0, 4'hF, "R7");
    sendOp(s, o, 16'hFFFF, 0, 0, 1, 0, 0, 4'hF, "R7");
    sendOp(s, o, 16'hFFFF, 1, 1, 2, 0, 0, 4'hF, "R7");
    // R8 reserved field
    sendOp(s, o, 16'hFFFF, 2, 0, 0, 0, 0, 4'hE, "R8");
    idle(2);
    // R10 back-to-back legal, then random mix
    for (int k = 0; k < 300; k++) begin
      logic [3:0] sp;
      sp = ($urandom % 8 == 0) ? 4'($urandom) : 4'hF;
      sendOp(rnd256(), rnd512(), 16'($urandom), int'($urandom % 4),
             bit'($urandom), int'($urandom % 4), bit'($urandom),
             bit'($urandom), sp, "R10");
      if ($urandom % 4 == 0) idle(1);
    end
    idle(4);
    check(expDestQ.size() == 0, "R10", "pending results", 512'(expDestQ.size()), 512'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule